// File: doc/BRIEF.md
# Serial mouse packet encoder

This block turns one mouse sample into a five-byte report for a serial mouse channel. A sample carries a signed horizontal step, a signed vertical step and three button flags, and is offered with a one-cycle valid strobe. The encoder builds a header byte from the buttons, clamps both motion values to a signed 8-bit range and flips the vertical direction. It then writes the header, the X byte, the Y byte and two zero bytes into a byte FIFO, one byte per clock.

A serial transmitter drains the FIFO through a valid/ready pair. A sample is only taken when the encoder is idle and the FIFO can hold a whole report, so a report is never split. A sample that cannot be taken is discarded and counted. Summing motion across several samples and framing bits on the serial line are left to neighbouring blocks.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset, `out_valid`, `busy`, `drop_count` and `fifo_level` are all zero.
- R2: Byte 0 of a report is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared for the middle button and bit 0 cleared for the right button.
- R3: Byte 1 is `smp_dx` clamped to the range -127..+127, as an 8-bit two's complement value (so 0x80 never appears).
- R4: Byte 2 is the negation of `smp_dy`, clamped to -127..+127 as 8-bit two's complement; a `smp_dy` of -32768 gives 0x7F.
- R5: Bytes 3 and 4 are always 0x00.
- R6: The FIFO presents the bytes of each report in the order byte 0, 1, 2, 3, 4, and reports leave in the order their samples were taken.
- R7: A sample is taken when `smp_valid` is high, `busy` is low and the FIFO has at least five free entries; from the next clock edge `busy` is high for exactly five cycles, during which one byte per cycle enters the FIFO, so `fifo_level` rises by five when nothing is read.
- R8: A sample offered while `busy` is high or while fewer than five FIFO entries are free adds nothing to the FIFO and raises `drop_count` by one.
- R9: `out_valid` is high whenever the FIFO holds a byte, `out_data` shows the oldest byte, a byte is removed on a clock edge where `out_valid` and `out_ready` are both high, and `out_ready` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_dx | input | IN_W (16) | Signed horizontal step |
| smp_dy | input | IN_W (16) | Signed vertical step |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| out_ready | input | 1 | Consumer takes the presented byte |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_data | output | 8 | Oldest byte in the FIFO |
| busy | output | 1 | A report is being written into the FIFO |
| fifo_level | output | LVL_W (5) | Number of bytes held in the FIFO |
| drop_count | output | DROP_W (16) | Number of discarded samples, wrapping |

## Verification
The bench builds the encoder with an eight-entry FIFO, so a single report already leaves only three free entries and the next sample must be dropped, while draining exactly two bytes brings the FIFO to the point where a report fits with no entry to spare and fills it completely. Motion inputs keep the 16-bit default, which puts the extreme values -32768 and +32767 and the negation overflow on the Y axis within reach. Back-to-back strobes exercise the drop path while the encoder is still writing.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN = 5;
  localparam logic [7:0] HDR_IDLE = 8'h87;
  localparam int SAT_MAG = 127;

  typedef logic [7:0] mbyte_t;
  typedef logic [PKT_LEN-1:0][7:0] pkt_t;
endpackage

// File: rtl/mpe_format.sv
module mpe_format
  import mpe_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] dx,
  input  logic [IN_W-1:0] dy,
  input  logic            b_left,
  input  logic            b_mid,
  input  logic            b_right,
  output pkt_t            pkt
);
  localparam int EW = IN_W + 1;
  localparam logic signed [EW-1:0] POS_LIM = EW'(SAT_MAG);
  localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM;

  function automatic mbyte_t hdr_byte(input logic l, input logic m, input logic r);
    mbyte_t h;
    h = HDR_IDLE;
    if (l) h[2] = 1'b0;
    if (m) h[1] = 1'b0;
    if (r) h[0] = 1'b0;
    return h;
  endfunction

  function automatic mbyte_t sat_byte(input logic signed [EW-1:0] v);
    if (v > POS_LIM)      return 8'h7F;
    else if (v < NEG_LIM) return 8'h81;
    else                  return v[7:0];
  endfunction

  logic signed [EW-1:0] dx_ext;
  logic signed [EW-1:0] dy_neg;

  assign dx_ext = {dx[IN_W-1], dx};
  assign dy_neg = -$signed({dy[IN_W-1], dy});

  assign pkt[0] = hdr_byte(b_left, b_mid, b_right);
  assign pkt[1] = sat_byte(dx_ext);
  assign pkt[2] = sat_byte(dy_neg);

  for (genvar g = 3; g < PKT_LEN; g++) begin : g_tail
    assign pkt[g] = 8'h00;
  end
endmodule

// File: rtl/mpe_admit.sv
module mpe_admit
  import mpe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DROP_W = 16,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              busy,
  input  logic [LVL_W-1:0]  level,
  output logic              accept,
  output logic              drop,
  output logic [DROP_W-1:0] drop_count
);
  logic [LVL_W-1:0] free_slots;
  logic             has_room;

  assign free_slots = LVL_W'(DEPTH) - level;
  assign has_room   = free_slots >= LVL_W'(PKT_LEN);
  assign accept     = valid && !busy && has_room;
  assign drop       = valid && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n)    drop_count <= '0;
    else if (drop) drop_count <= drop_count + 1'b1;
  end
endmodule

// File: rtl/mpe_sequencer.sv
module mpe_sequencer
  import mpe_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  pkt_t             pkt_in,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output mbyte_t           wr_byte
);
  pkt_t             pkt_q;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_q <= '0;
      idx   <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      pkt_q <= pkt_in;
      idx   <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      if (idx == IDX_W'(PKT_LEN - 1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign wr_en   = busy;
  assign wr_idx  = idx;
  assign wr_byte = pkt_q[idx];
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    else                     return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (rd_en) rd_ptr <= ptr_next(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (level == '0);
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [IN_W-1:0]   smp_dx,
  input  logic [IN_W-1:0]   smp_dy,
  input  logic              btn_left,
  input  logic              btn_mid,
  input  logic              btn_right,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              busy,
  output logic [LVL_W-1:0]  fifo_level,
  output logic [DROP_W-1:0] drop_count
);
  localparam int IDX_W = $clog2(PKT_LEN);

  // named internal events, observed by the bound checker
  pkt_t             fmt_pkt;
  logic             acc_evt;
  logic             drop_evt;
  logic             wr_evt;
  logic [IDX_W-1:0] wr_idx;
  mbyte_t           wr_byte;
  logic             rd_evt;
  logic             fifo_empty;

  mpe_format #(.IN_W(IN_W)) u_fmt (
    .dx      (smp_dx),
    .dy      (smp_dy),
    .b_left  (btn_left),
    .b_mid   (btn_mid),
    .b_right (btn_right),
    .pkt     (fmt_pkt)
  );

  mpe_admit #(.DEPTH(FIFO_DEPTH), .DROP_W(DROP_W), .LVL_W(LVL_W)) u_admit (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (smp_valid),
    .busy       (busy),
    .level      (fifo_level),
    .accept     (acc_evt),
    .drop       (drop_evt),
    .drop_count (drop_count)
  );

  mpe_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (acc_evt),
    .pkt_in  (fmt_pkt),
    .busy    (busy),
    .wr_en   (wr_evt),
    .wr_idx  (wr_idx),
    .wr_byte (wr_byte)
  );

  assign rd_evt = out_ready && !fifo_empty;

  mpe_fifo #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_evt),
    .wr_data (wr_byte),
    .rd_en   (rd_evt),
    .rd_data (out_data),
    .empty   (fifo_empty),
    .level   (fifo_level)
  );

  assign out_valid = !fifo_empty;
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
  parameter int DEPTH  = 16,
  parameter int DROP_W = 16,
  parameter int LVL_W  = 5,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              busy,
  input logic              acc_evt,
  input logic              wr_evt,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [7:0]        wr_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LVL_W-1:0]  fifo_level,
  input logic [DROP_W-1:0] drop_count
);
  AST_HDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_idx == '0) |-> (wr_byte[7:3] == 5'b10000)); // R2
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (wr_idx == IDX_W'(1) || wr_idx == IDX_W'(2))) |-> (wr_byte != 8'h80)); // R3
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_idx >= IDX_W'(3)) |-> (wr_byte == 8'h00)); // R5
  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> (busy && wr_evt && wr_idx == '0)); // R7
  AST_END_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_idx == IDX_W'(4)) |=> !busy); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> (fifo_level < LVL_W'(DEPTH))); // R7
  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !acc_evt) |=> (drop_count == $past(drop_count) + 1'b1)); // R8
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(drop_count)); // R8
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !wr_evt) |=> !out_valid); // R9
endmodule

bind mouse_pkt_enc mpe_checker #(
  .DEPTH(FIFO_DEPTH), .DROP_W(DROP_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .busy       (busy),
  .acc_evt    (acc_evt),
  .wr_evt     (wr_evt),
  .wr_idx     (wr_idx),
  .wr_byte    (wr_byte),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .fifo_level (fifo_level),
  .drop_count (drop_count)
);

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb;
  localparam int IN_W   = 16;
  localparam int DEPTH  = 8;
  localparam int DROP_W = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [IN_W-1:0]   smp_dx = '0;
  logic [IN_W-1:0]   smp_dy = '0;
  logic              btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
  logic              out_ready = 1'b0;
  logic              out_valid;
  logic [7:0]        out_data;
  logic              busy;
  logic [LVL_W-1:0]  fifo_level;
  logic [DROP_W-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  int exp_drops = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  mouse_pkt_enc #(.IN_W(IN_W), .FIFO_DEPTH(DEPTH), .DROP_W(DROP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_dx(smp_dx), .smp_dy(smp_dy),
    .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .busy(busy), .fifo_level(fifo_level),
    .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int clamp127(input int v);
    return (v > 127) ? 127 : ((v < -127) ? -127 : v);
  endfunction

  // expected report, computed from R2..R5 independently
  task automatic push_expected(input int dx, input int dy, input bit l, input bit m, input bit r);
    logic [7:0] hdr;
    hdr = 8'h87 & ~{5'b00000, l, m, r};
    exp_q.push_back(hdr);                      tag_q.push_back("R2/R6 header");
    exp_q.push_back(8'(clamp127(dx)));         tag_q.push_back("R3/R6 x byte");
    exp_q.push_back(8'(clamp127(-dy)));        tag_q.push_back("R4/R6 y byte");
    exp_q.push_back(8'h00);                    tag_q.push_back("R5/R6 zero byte");
    exp_q.push_back(8'h00);                    tag_q.push_back("R5/R6 zero byte");
  endtask

  task automatic drive(input int dx, input int dy, input bit l, input bit m, input bit r);
    smp_valid = 1'b1;
    smp_dx = IN_W'(dx); smp_dy = IN_W'(dy);
    btn_left = l; btn_mid = m; btn_right = r;
  endtask

  task automatic send(input int dx, input int dy, input bit l, input bit m, input bit r,
                      input bit accept);
    @(posedge clk); #1;
    drive(dx, dy, l, m, r);
    if (accept) push_expected(dx, dy, l, m, r);
    else exp_drops++;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected byte", out_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == e, t, out_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(drop_count == '0, "R1 drop_count", drop_count, 0);
    chk(fifo_level == '0, "R1 fifo_level", fifo_level, 0);

    // R7 busy window: high for exactly five cycles after the accept edge
    @(posedge clk); #1;
    drive(3, 4, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    smp_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R7 busy during write", busy, 1);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy released", busy, 0);
    chk(fifo_level == LVL_W'(5), "R7 level after report", fifo_level, 5);
    // drain that report with its expected contents
    push_expected(3, 4, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1 out_ready = 1'b1;
    wait_drain();

    // main function, several patterns (R2, R3, R4, R5, R6)
    send(0, 0, 0, 0, 0, 1);            wait_idle();
    send(5, 3, 1, 0, 0, 1);            wait_idle();
    send(-1, -5, 0, 1, 0, 1);          wait_idle();
    send(200, -200, 0, 0, 1, 1);       wait_idle();
    send(-300, 300, 1, 1, 1, 1);       wait_idle();
    send(-32768, -32768, 1, 0, 1, 1);  wait_idle();   // R4 negation overflow
    send(32767, 32767, 0, 1, 1, 1);    wait_idle();
    send(127, -127, 0, 0, 0, 1);       wait_idle();
    send(-127, 127, 0, 0, 0, 1);       wait_idle();
    send(128, -128, 1, 1, 0, 1);       wait_idle();
    wait_drain();
    chk(drop_count == DROP_W'(exp_drops), "R8 no drops yet", drop_count, exp_drops);

    // R8 drop for lack of room
    @(posedge clk); #1 out_ready = 1'b0;
    send(10, 20, 1, 0, 0, 1);          wait_idle();
    chk(fifo_level == LVL_W'(5), "R7 level five", fifo_level, 5);
    send(-7, 9, 0, 0, 1, 0);           wait_idle();
    @(negedge clk);
    chk(drop_count == DROP_W'(exp_drops), "R8 drop when full", drop_count, exp_drops);
    chk(fifo_level == LVL_W'(5), "R8 dropped sample adds nothing", fifo_level, 5);

    // R7 exact fit: drain two bytes, leaving five free
    @(posedge clk); #1 out_ready = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    chk(fifo_level == LVL_W'(3), "R9 two pops", fifo_level, 3);
    send(-60, -70, 0, 1, 0, 1);        wait_idle();
    @(negedge clk);
    chk(fifo_level == LVL_W'(DEPTH), "R7 exact fit fills fifo", fifo_level, DEPTH);
    chk(out_valid == 1'b1, "R9 out_valid when holding", out_valid, 1);

    // R8 drop while busy: back-to-back strobes
    @(posedge clk); #1 out_ready = 1'b1;
    wait_drain();
    @(posedge clk); #1;
    drive(33, -44, 0, 0, 1);
    push_expected(33, -44, 0, 0, 1);
    @(posedge clk); #1;
    drive(55, 66, 1, 1, 1);
    exp_drops++;
    @(posedge clk); #1;
    smp_valid = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(drop_count == DROP_W'(exp_drops), "R8 drop while busy", drop_count, exp_drops);
    wait_drain();

    // R9 ready while empty has no effect
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R9 empty stays empty", out_valid, 0);
    chk(fifo_level == '0, "R9 level stays zero", fifo_level, 0);
    send(1, -1, 0, 0, 0, 1);           wait_idle();
    wait_drain();
    chk(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule